// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

The bridge sits on the bus in front of a region of backing memory. It answers accesses to a 32 MB alias window in which every 32-bit alias word stands for one bit of the backing region. An alias read returns that one bit as 0 or 1. An alias write sets or clears that one bit. The write is done as a read-modify-write of the backing datum, and the datum is as wide as the access: byte, halfword or word.

A request arrives on a valid/ready slave port. It carries the address, the size, a write flag and the write data. The bridge turns the request into a backing address and a bit position. It then runs one read, or one read followed by one write, on its master port to the backing memory, and returns a one-cycle response. The base address of the backing region is a parameter. The bridge takes no new request until the current response has been issued, so the read-modify-write cannot be split by another access.

Top module: `bitband_bridge`

## Requirements
- R1: Only the low 25 bits of `s_addr` (the offset in the window) are used. The backing byte address is `BACKING_BASE | (offset >> 5)`, and every master request falls inside the region above `BACKING_BASE`.
- R2: Size codes are 0 for byte, 1 for halfword and 2 or 3 for word. A halfword access clears bit 0 of the backing address, and a word access clears bits 1:0. `m_size` repeats the request size. `m_strb` enables byte lanes from the aligned address `a`: `1 << a[1:0]` for a byte, `3 << a[1:0]` for a halfword, and `4'hF` for a word.
- R3: The bit selected in the datum is `(offset >> 2)` kept to its low 3, 4 or 5 bits for byte, halfword or word. The datum sits little-endian on the 32-bit master data bus, with byte lane k at bits 8k+7:8k. As a result, alias offset `o` always names bit `o >> 2` of the region when the region is counted from bit 0 of its first byte.
- R4: A read response carries the selected bit in `s_rdata[0]`, and bits 31:1 are zero. A write response carries all zeros.
- R5: A write reads the datum and then writes it back at the same address and size. Only the selected bit changes, and it takes the value of `s_wdata[0]`. Bits 31:1 of `s_wdata` have no effect.
- R6: `s_ready` is low from the cycle after acceptance until the response has been issued. A master request holds `m_valid`, `m_addr` and `m_write` steady until `m_ready` is seen.
- R7: `s_rsp_valid` is a one-cycle pulse. When `m_ready` is high and read data returns in the cycle after the read is accepted, the response is due 3 cycles after acceptance for a read and 4 cycles after for a write.
- R8: Reset, including reset in the middle of an operation, returns the bridge to idle. `s_ready` is 1, `m_valid` and `s_rsp_valid` are 0, and no write reaches the backing memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Alias request valid |
| s_ready | output | 1 | Bridge idle and able to take a request |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| s_addr | input | 32 | Alias address (low 25 bits used) |
| s_wdata | input | 32 | Write data (bit 0 used) |
| s_rsp_valid | output | 1 | Response pulse |
| s_rdata | output | 32 | Read result, 0 or 1 |
| m_valid | output | 1 | Backing request valid |
| m_ready | input | 1 | Backing request accepted |
| m_write | output | 1 | Backing request is a write |
| m_size | output | 2 | Backing access size |
| m_addr | output | 32 | Backing byte address |
| m_strb | output | 4 | Byte-lane enables |
| m_wdata | output | 32 | Write-back datum, lanes outside m_strb zero |
| m_rvalid | input | 1 | Backing read data valid |
| m_rdata | input | 32 | Backing read data (aligned 32-bit word) |

## Verification
The memory model in the bench accepts every request at once and returns read data one cycle later. With that model, a read response is due at the third falling edge after the accepting rising edge, and a write response at the fourth. For the vector table, the bench counts falling edges from the accepting edge and compares that count with 3 or 4. One falling edge after each response it checks that the pulse has dropped. The backing address and lane enables are latched by the model on the read request, and the memory is compared with the reference bit array only after the response. Under stalled `m_ready` the latency is not fixed, so those runs check only data, addresses and memory contents.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int BB_DW    = 32;
  localparam int BB_AW    = 32;
  localparam int WIN_BITS = 25;
  localparam int LANES    = BB_DW / 8;
  localparam int BIT_W    = $clog2(BB_DW);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_RESP
  } bb_state_e;

  // byte address of the backing datum, aligned to the access size
  function automatic logic [BB_AW-1:0] bb_backing_addr(
      input logic [BB_AW-1:0]    base,
      input logic [WIN_BITS-1:0] off,
      input logic [1:0]          size);
    logic [BB_AW-1:0] a;
    a = base | BB_AW'(off >> 5);
    if (size == SZ_HALF)      a[0]   = 1'b0;
    else if (size != SZ_BYTE) a[1:0] = 2'b00;
    return a;
  endfunction

  // bit index on the little-endian data bus
  function automatic logic [BIT_W-1:0] bb_bus_bit(
      input logic [1:0]          lo,
      input logic [WIN_BITS-1:0] off,
      input logic [1:0]          size);
    logic [BIT_W-1:0] p;
    if (size == SZ_BYTE)      p = {2'b00, off[4:2]};
    else if (size == SZ_HALF) p = {1'b0, off[5:2]};
    else                      p = off[6:2];
    return {lo, 3'b000} + p;
  endfunction

  function automatic logic [LANES-1:0] bb_strb(
      input logic [1:0] size, input logic [1:0] lo);
    if (size == SZ_BYTE)      return 4'b0001 << lo;
    else if (size == SZ_HALF) return 4'b0011 << lo;
    else                      return 4'b1111;
  endfunction

  function automatic logic [BB_DW-1:0] bb_lane_mask(input logic [LANES-1:0] strb);
    logic [BB_DW-1:0] m;
    for (int k = 0; k < LANES; k++) m[8*k +: 8] = {8{strb[k]}};
    return m;
  endfunction

  function automatic logic [BB_DW-1:0] bb_put_bit(
      input logic [BB_DW-1:0] d, input logic [BIT_W-1:0] b, input logic v);
    logic [BB_DW-1:0] r;
    r    = d;
    r[b] = v;
    return r;
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter logic [BB_AW-1:0] BASE = 32'h2000_0000
) (
  input  logic [WIN_BITS-1:0] off,
  input  logic [1:0]          size,
  output logic [BB_AW-1:0]    baddr,
  output logic [BIT_W-1:0]    bus_bit,
  output logic [LANES-1:0]    strb
);
  always_comb begin
    baddr   = bb_backing_addr(BASE, off, size);
    bus_bit = bb_bus_bit(baddr[1:0], off, size);
    strb    = bb_strb(size, baddr[1:0]);
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             req_write,
  input  logic             req_bit,
  input  logic [1:0]       req_size,
  input  logic [BB_AW-1:0] req_addr,
  input  logic [BIT_W-1:0] req_bus_bit,
  input  logic [LANES-1:0] req_strb,
  output logic             idle,
  output logic             rsp_valid,
  output logic [BB_DW-1:0] rsp_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_write,
  output logic [1:0]       m_size,
  output logic [BB_AW-1:0] m_addr,
  output logic [LANES-1:0] m_strb,
  output logic [BB_DW-1:0] m_wdata,
  input  logic             m_rvalid,
  input  logic [BB_DW-1:0] m_rdata
);
  bb_state_e        state;
  logic             write_q, wbit_q, rbit_q;
  logic [1:0]       size_q;
  logic [BB_AW-1:0] addr_q;
  logic [BIT_W-1:0] bit_q;
  logic [LANES-1:0] strb_q;
  logic [BB_DW-1:0] datum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      write_q <= 1'b0;
      wbit_q  <= 1'b0;
      rbit_q  <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      bit_q   <= '0;
      strb_q  <= '0;
      datum_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          write_q <= req_write;
          wbit_q  <= req_bit;
          size_q  <= req_size;
          addr_q  <= req_addr;
          bit_q   <= req_bus_bit;
          strb_q  <= req_strb;
          state   <= ST_RD_REQ;
        end
        ST_RD_REQ:  if (m_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (m_rvalid) begin
          datum_q <= m_rdata;
          rbit_q  <= m_rdata[bit_q];
          state   <= write_q ? ST_WR_REQ : ST_RESP;
        end
        ST_WR_REQ:  if (m_ready) state <= ST_RESP;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle      = (state == ST_IDLE);
    rsp_valid = (state == ST_RESP);
    rsp_data  = {{(BB_DW-1){1'b0}}, rbit_q & ~write_q};
    m_valid   = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    m_write   = (state == ST_WR_REQ);
    m_size    = size_q;
    m_addr    = addr_q;
    m_strb    = strb_q;
    m_wdata   = bb_put_bit(datum_q, bit_q, wbit_q) & bb_lane_mask(strb_q);
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] BACKING_BASE = 32'h2000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic        s_write,
  input  logic [1:0]  s_size,
  input  logic [31:0] s_addr,
  input  logic [31:0] s_wdata,
  output logic        s_rsp_valid,
  output logic [31:0] s_rdata,
  output logic        m_valid,
  input  logic        m_ready,
  output logic        m_write,
  output logic [1:0]  m_size,
  output logic [31:0] m_addr,
  output logic [3:0]  m_strb,
  output logic [31:0] m_wdata,
  input  logic        m_rvalid,
  input  logic [31:0] m_rdata
);
  logic [BB_AW-1:0] dec_addr;
  logic [BIT_W-1:0] dec_bit;
  logic [LANES-1:0] dec_strb;
  logic             accept;
  logic             unused_hi;

  assign unused_hi = ^{s_addr[BB_AW-1:WIN_BITS], s_wdata[BB_DW-1:1]};
  assign accept    = s_valid && s_ready;

  bb_decode #(.BASE(BACKING_BASE)) u_decode (
    .off     (s_addr[WIN_BITS-1:0]),
    .size    (s_size),
    .baddr   (dec_addr),
    .bus_bit (dec_bit),
    .strb    (dec_strb)
  );

  bb_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_write   (s_write),
    .req_bit     (s_wdata[0]),
    .req_size    (s_size),
    .req_addr    (dec_addr),
    .req_bus_bit (dec_bit),
    .req_strb    (dec_strb),
    .idle        (s_ready),
    .rsp_valid   (s_rsp_valid),
    .rsp_data    (s_rdata),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_write     (m_write),
    .m_size      (m_size),
    .m_addr      (m_addr),
    .m_strb      (m_strb),
    .m_wdata     (m_wdata),
    .m_rvalid    (m_rvalid),
    .m_rdata     (m_rdata)
  );
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
  parameter logic [31:0] BASE = 32'h2000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic        s_rsp_valid,
  input logic [31:1] s_rdata_hi,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_write,
  input logic [1:0]  m_size,
  input logic [31:0] m_addr,
  input logic [3:0]  m_strb,
  input logic [31:0] m_wdata,
  input logic        m_rvalid,
  input logic [31:0] m_rdata
);
  localparam logic [31:0] HI_MASK = 32'hFFF0_0000;

  logic        seen_rd;
  logic [31:0] rd_addr_q, rd_data_q, lane_m;

  always_comb
    for (int k = 0; k < 4; k++) lane_m[8*k +: 8] = {8{m_strb[k]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_rd   <= 1'b0;
      rd_addr_q <= '0;
      rd_data_q <= '0;
    end else begin
      if (m_valid && m_ready && !m_write) begin
        seen_rd   <= 1'b1;
        rd_addr_q <= m_addr;
      end else if (s_rsp_valid) begin
        seen_rd <= 1'b0;
      end
      if (m_rvalid) rd_data_q <= m_rdata;
    end
  end

  assert_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_addr & HI_MASK) == (BASE & HI_MASK));
  assert_half_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_size == 2'd1 |-> !m_addr[0]);
  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_size[1] |-> m_addr[1:0] == 2'b00);
  assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> $countones(m_strb) == (m_size == 2'd0 ? 1 : (m_size == 2'd1 ? 2 : 4)));
  assert_rdata_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_rsp_valid |-> s_rdata_hi == '0);
  assert_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_write |-> seen_rd && m_addr == rd_addr_q);
  assert_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_write |-> $countones((m_wdata ^ rd_data_q) & lane_m) <= 1);
  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> !s_ready);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write));
  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_rsp_valid |=> !s_rsp_valid);

  always @(posedge clk)
    if (!rst_n) assert_reset_idle_R8: assert (s_ready && !m_valid && !s_rsp_valid);
endmodule

bind bitband_bridge bb_checker #(.BASE(BACKING_BASE)) u_bb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .s_rsp_valid (s_rsp_valid),
  .s_rdata_hi  (s_rdata[31:1]),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_write     (m_write),
  .m_size      (m_size),
  .m_addr      (m_addr),
  .m_strb      (m_strb),
  .m_wdata     (m_wdata),
  .m_rvalid    (m_rvalid),
  .m_rdata     (m_rdata)
);

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  localparam logic [31:0] BASE  = 32'h2000_0000;
  localparam logic [31:0] ALIAS = 32'h2200_0000;
  localparam int NVEC = 13;
  // {write, size, offset[24:0], wdata[31:0], expected bit}
  localparam logic [60:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 25'h0000, 32'h0000_0001, 1'b0},
    {1'b0, 2'd2, 25'h0000, 32'h0,         1'b1},
    {1'b0, 2'd1, 25'h0004, 32'h0,         1'b0},
    {1'b1, 2'd1, 25'h0024, 32'hFFFF_FFFF, 1'b0},
    {1'b0, 2'd0, 25'h0024, 32'h0,         1'b1},
    {1'b1, 2'd2, 25'h07FC, 32'h0000_0003, 1'b0},
    {1'b0, 2'd0, 25'h07FC, 32'h0,         1'b1},
    {1'b1, 2'd0, 25'h0000, 32'hFFFF_FFFE, 1'b0},
    {1'b0, 2'd1, 25'h0000, 32'h0,         1'b0},
    {1'b0, 2'd2, 25'h0020, 32'h0,         1'b0},
    {1'b1, 2'd3, 25'h1FE0, 32'h0000_0001, 1'b0},
    {1'b0, 2'd1, 25'h1FE0, 32'h0,         1'b1},
    {1'b0, 2'd2, 25'h0024, 32'h0,         1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_ready, s_write, s_rsp_valid;
  logic [1:0]  s_size;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic m_valid, m_ready, m_write, m_rvalid;
  logic [1:0]  m_size;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_strb;

  logic [31:0] mem [64];
  logic        ref_bits [2048];
  logic        stall_en, ready_tgl;
  logic [31:0] last_addr;
  logic [3:0]  last_strb;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bitband_bridge #(.BACKING_BASE(BASE)) i_bitband_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_size(s_size),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_size(m_size),
    .m_addr(m_addr), .m_strb(m_strb), .m_wdata(m_wdata),
    .m_rvalid(m_rvalid), .m_rdata(m_rdata)
  );

  assign m_ready = !stall_en || ready_tgl;

  // backing memory: accepts at once, read data one cycle later
  always @(posedge clk) begin
    ready_tgl <= !ready_tgl;
    if (!rst_n) begin
      m_rvalid <= 1'b0;
    end else begin
      m_rvalid <= 1'b0;
      if (m_valid && m_ready) begin
        if (m_write) begin
          for (int k = 0; k < 4; k++)
            if (m_strb[k]) mem[m_addr[7:2]][8*k +: 8] <= m_wdata[8*k +: 8];
        end else begin
          m_rvalid  <= 1'b1;
          m_rdata   <= mem[m_addr[7:2]];
          last_addr <= m_addr;
          last_strb <= m_strb;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat,
                        output bit busy_ok);
    lat = 0; busy_ok = 1'b1; rd = 'x;
    @(negedge clk);
    s_valid = 1'b1; s_write = w; s_size = sz; s_addr = addr; s_wdata = wd;
    @(posedge clk);
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == 1) s_valid = 1'b0;
      if (s_rsp_valid) begin lat = i; rd = s_rdata; break; end
      if (s_ready) busy_ok = 1'b0;
    end
  endtask

  task automatic mem_compare(input string req);
    int bad = 0;
    for (int g = 0; g < 2048; g++)
      if (mem[g >> 5][g & 31] !== ref_bits[g]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  function automatic logic [31:0] exp_addr(input logic [24:0] off, input logic [1:0] sz);
    logic [31:0] byte_a;
    byte_a = BASE + 32'(off / 32);
    if (sz == 2'd1) return byte_a & ~32'd1;
    if (sz >= 2'd2) return byte_a & ~32'd3;
    return byte_a;
  endfunction

  function automatic logic [3:0] exp_strb(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return 4'(1 << (a % 4));
    if (sz == 2'd1) return (a % 4 == 0) ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    bit busy_ok;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int g = 0; g < 2048; g++) ref_bits[g] = 1'b0;
    s_valid = 0; s_write = 0; s_size = 0; s_addr = 0; s_wdata = 0;
    stall_en = 0; ready_tgl = 0; m_rdata = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(s_ready && !m_valid && !s_rsp_valid, "R8 reset idle", {s_ready, m_valid, s_rsp_valid}, 3'b100);
    rst_n = 1'b1;

    // vector table, no stalls
    for (int v = 0; v < NVEC; v++) begin
      logic        w, e;
      logic [1:0]  sz;
      logic [24:0] off;
      logic [31:0] wd;
      {w, sz, off, wd, e} = VEC[v];
      access(w, sz, ALIAS | 32'(off), wd, rd, lat, busy_ok);
      check(rd == {31'b0, e}, w ? "R4 write response zero" : "R3 R4 read bit", rd, {31'b0, e});
      check(lat == (w ? 4 : 3), "R7 latency", lat, w ? 4 : 3);
      check(busy_ok, "R6 ready low while busy", 0, 1);
      check(last_addr == exp_addr(off, sz), "R1 R2 backing address", last_addr, exp_addr(off, sz));
      check(last_strb == exp_strb(last_addr, sz), "R2 lane enables", last_strb, exp_strb(last_addr, sz));
      if (w) ref_bits[off >> 2] = wd[0];
      @(negedge clk);
      check(!s_rsp_valid, "R7 one-cycle pulse", s_rsp_valid, 0);
      mem_compare("R5 memory after table step");
    end

    // upper address bits outside the window are ignored
    access(1'b0, 2'd0, 32'h5E00_0024, 32'h0, rd, lat, busy_ok);
    check(rd == 32'd1, "R1 high alias bits ignored", rd, 1);
    check(last_addr == BASE + 32'd1, "R1 backing address", last_addr, BASE + 32'd1);

    // random accesses, then with stalled ready
    for (int phase = 0; phase < 2; phase++) begin
      stall_en = phase[0];
      for (int n = 0; n < 200; n++) begin
        logic        w;
        logic [1:0]  sz;
        logic [24:0] off;
        logic [31:0] wd;
        logic        e;
        w   = 1'($urandom_range(0, 1));
        sz  = 2'($urandom_range(0, 3));
        off = 25'($urandom_range(0, 32'h1FFF));
        wd  = $urandom;
        e   = w ? 1'b0 : ref_bits[off >> 2];
        access(w, sz, ALIAS | 32'(off), wd, rd, lat, busy_ok);
        check(rd == {31'b0, e}, "R3 R4 random access", rd, {31'b0, e});
        check(last_addr == exp_addr(off, sz), "R1 R2 random address", last_addr, exp_addr(off, sz));
        check(busy_ok, "R6 ready low while busy", 0, 1);
        if (w) ref_bits[off >> 2] = wd[0];
        mem_compare("R5 random memory");
      end
    end
    stall_en = 0;

    // reset in the middle of a write
    @(negedge clk);
    s_valid = 1; s_write = 1; s_size = 2'd2; s_addr = ALIAS | 32'h40; s_wdata = 32'h1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 0;
    check(m_valid && !m_write, "R8 read issued before reset", m_valid, 1);
    rst_n = 1'b0;
    #1;
    check(s_ready && !m_valid && !s_rsp_valid, "R8 mid-op reset idle", {s_ready, m_valid, s_rsp_valid}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mem_compare("R8 no write after reset");
    access(1'b0, 2'd2, ALIAS | 32'h40, 32'h0, rd, lat, busy_ok);
    check(rd == {31'b0, ref_bits[16]}, "R8 bridge usable after reset", rd, {31'b0, ref_bits[16]});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule